// File: doc/BRIEF.md
# Microcoded Waveform Sequencer

This block is a small interface state machine whose behaviour comes entirely from a downloaded descriptor memory. The memory holds four waveforms. Each waveform describes seven working states plus a resting state (state 7). A state is either a timed state or a branching state. A timed state holds for a programmed number of clocks and can capture the input bus into a downstream FIFO on every one of those clocks. A branching state lasts one clock, combines two selected status flags with a two-input logic function, and jumps to one of two target states.

Software writes the descriptors through a byte-wide port. It also supplies a static map from transaction type to waveform index. A trigger pulse carrying a 2-bit transaction type launches the mapped waveform. An abort input returns the engine to rest at any time. While the engine rests, it raises `done`. Captured bytes leave on `smp_data` together with a one-clock `smp_we` strobe.

Top module: `wsq_engine`

## Requirements
- R1: After reset, `done` is 1, `smp_we` is 0 and every descriptor byte reads as zero.
- R2: Descriptor byte address = waveform*32 + group*8 + state. The groups are: 0 = length/branch, 1 = opcode, 2 = output (stored, never used), 3 = logic function. Byte 7 of every group is never used by the engine.
- R3: While resting, a `trig` pulse selects waveform `wf_map[2*trig_type+1 : 2*trig_type]`. The engine enters state 0 at that clock edge, and `done` falls right after it.
- R4: A timed state (opcode bit 0 = 0) lasts max(1, length) clocks and then moves to the next state number. Leaving state 6 enters rest.
- R5: Opcode bit 1 = 1 captures `din` on every clock spent in that state. The captured byte appears on `smp_data`, with `smp_we` high, in the clock after the capture edge.
- R6: A branching state (opcode bit 0 = 1) lasts one clock. It goes to branch bits [5:3] when the logic result is 1, and to bits [2:0] when the result is 0.
- R7: Logic byte: bits [7:6] pick the function (0 = A AND B, 1 = A OR B, 2 = A XOR B, 3 = A AND NOT B). Bits [5:3] pick flag A and bits [2:0] pick flag B. Flag 1 is constant 1, flag 6 is `fifo_full`, flag 7 is `fifo_empty`, and all other flags are 0.
- R8: A branch to state 7 ends the waveform and raises `done` in the next clock. If branch bit 7 is set, the engine re-enters state 0 instead.
- R9: `abort` forces rest at the next edge, before a trigger or any transition. The clock in which abort is high captures nothing.
- R10: A trigger that arrives while the engine is running has no effect on the running waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Descriptor byte write enable |
| cfg_addr | input | 7 | Descriptor byte address |
| cfg_wdata | input | 8 | Descriptor byte value |
| wf_map | input | 8 | Transaction type to waveform index map, 2 bits per type |
| trig | input | 1 | Start request while resting |
| trig_type | input | 2 | Transaction type for the start request |
| abort | input | 1 | Force rest |
| fifo_full | input | 1 | Downstream FIFO full flag |
| fifo_empty | input | 1 | Downstream FIFO empty flag |
| din | input | 8 | Sampled input bus |
| smp_we | output | 1 | Capture strobe towards the FIFO |
| smp_data | output | 8 | Captured byte |
| done | output | 1 | Engine resting |

## Verification
A wrong state register or a wrong hold counter does not stay hidden. It changes how many clocks `done` stays low, and it changes which clocks carry a `smp_we` pulse. Both shift within one waveform pass, which is usually a few clocks after the trigger. The gaps between captured `din` values expose a hold length that is off by one. Sweeping all function codes against all four flag combinations sends a wrong branch decode down a path of a different length, so it shows at the ports in the very next waveform.

// File: rtl/wsq_pkg.sv
package wsq_pkg;

   localparam int BYTE_W      = 8;
   localparam int STATE_W     = 3;
   localparam int N_STATES    = 8;
   localparam int GROUP_BYTES = 8;
   localparam int WF_BYTES    = 4 * GROUP_BYTES;
   localparam logic [STATE_W-1:0] REST_ST = 3'd7;

   typedef enum logic [1:0] {
      LF_AND  = 2'd0,
      LF_OR   = 2'd1,
      LF_XOR  = 2'd2,
      LF_ANDN = 2'd3
   } lf_op_e;

   typedef struct packed {
      logic               rerun;
      logic               spare;
      logic [STATE_W-1:0] tgt_hi;
      logic [STATE_W-1:0] tgt_lo;
   } branch_t;

   typedef struct packed {
      lf_op_e             fn;
      logic [STATE_W-1:0] sel_a;
      logic [STATE_W-1:0] sel_b;
   } lfunc_t;

   function automatic logic lf_apply(lf_op_e fn, logic a, logic b);
      unique case (fn)
         LF_AND:  return a & b;
         LF_OR:   return a | b;
         LF_XOR:  return a ^ b;
         default: return a & ~b;
      endcase
   endfunction

endpackage

// File: rtl/wsq_desc_mem.sv
module wsq_desc_mem
   import wsq_pkg::*;
#(
   parameter int NUM_WF = 4,
   localparam int WF_W   = $clog2(NUM_WF),
   localparam int ADDR_W = WF_W + $clog2(WF_BYTES)
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [ADDR_W-1:0]  waddr,
   input  logic [BYTE_W-1:0]  wdata,
   input  logic [WF_W-1:0]    rd_wf,
   input  logic [STATE_W-1:0] rd_st,
   output logic [BYTE_W-1:0]  len_br,
   output logic [1:0]         op_bits,
   output logic [BYTE_W-1:0]  lfunc
);

   localparam int OFF_W = $clog2(WF_BYTES);

   logic [BYTE_W-1:0] len_w [NUM_WF];
   logic [BYTE_W-1:0] op_w  [NUM_WF];
   logic [BYTE_W-1:0] lf_w  [NUM_WF];

   for (genvar w = 0; w < NUM_WF; w++) begin : g_bank
      logic [BYTE_W-1:0] bank [WF_BYTES];
      logic              hit;

      assign hit = we && (waddr[ADDR_W-1:OFF_W] == WF_W'(w));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < WF_BYTES; i++) bank[i] <= '0;
         end else if (hit) begin
            bank[waddr[OFF_W-1:0]] <= wdata;
         end
      end

      assign len_w[w] = bank[{2'd0, rd_st}];
      assign op_w[w]  = bank[{2'd1, rd_st}];
      assign lf_w[w]  = bank[{2'd3, rd_st}];
   end

   logic [BYTE_W-1:0] op_sel;

   assign len_br  = len_w[rd_wf];
   assign op_sel  = op_w[rd_wf];
   assign op_bits = op_sel[1:0];
   assign lfunc   = lf_w[rd_wf];

   logic unused_op;
   assign unused_op = ^op_sel[BYTE_W-1:2];

endmodule

// File: rtl/wsq_flag_eval.sv
module wsq_flag_eval
   import wsq_pkg::*;
(
   input  logic              fifo_full,
   input  logic              fifo_empty,
   input  logic [BYTE_W-1:0] lfunc,
   output logic              cond
);

   logic [N_STATES-1:0] flags;
   lfunc_t              lf;

   for (genvar i = 0; i < N_STATES; i++) begin : g_flag
      if (i == 6) begin : g_full
         assign flags[i] = fifo_full;
      end else if (i == 7) begin : g_empty
         assign flags[i] = fifo_empty;
      end else if (i == 1) begin : g_one
         assign flags[i] = 1'b1;
      end else begin : g_zero
         assign flags[i] = 1'b0;
      end
   end

   assign lf   = lfunc_t'(lfunc);
   assign cond = lf_apply(lf.fn, flags[lf.sel_a], flags[lf.sel_b]);

endmodule

// File: rtl/wsq_sampler.sv
module wsq_sampler #(
   parameter int DATA_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [DATA_W-1:0] din,
   output logic              we,
   output logic [DATA_W-1:0] data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we   <= 1'b0;
         data <= '0;
      end else begin
         we <= take;
         if (take) data <= din;
      end
   end

endmodule

// File: rtl/wsq_ctrl.sv
module wsq_ctrl
   import wsq_pkg::*;
#(
   parameter int NUM_WF  = 4,
   parameter int N_TYPES = 4,
   localparam int WF_W = $clog2(NUM_WF),
   localparam int TY_W = $clog2(N_TYPES)
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    trig,
   input  logic [TY_W-1:0]         trig_type,
   input  logic [N_TYPES*WF_W-1:0] wf_map,
   input  logic                    abort,
   input  logic [BYTE_W-1:0]       len_br,
   input  logic [1:0]              op_bits,
   input  logic                    cond,
   output logic [WF_W-1:0]         cur_wf,
   output logic [STATE_W-1:0]      cur_st,
   output logic                    take,
   output logic                    resting
);

   logic [STATE_W-1:0] st_q, st_d;
   logic [WF_W-1:0]    wf_q, wf_d;
   logic [BYTE_W-1:0]  cnt_q, cnt_d;
   logic               busy, is_dp, is_xfer, hold_over;
   logic [STATE_W-1:0] tgt;
   branch_t            br;

   assign br        = branch_t'(len_br);
   assign busy      = (st_q != REST_ST);
   assign is_dp     = op_bits[0];
   assign is_xfer   = op_bits[1];
   assign hold_over = ({1'b0, cnt_q} + 9'd1) >= {1'b0, len_br};
   assign tgt       = cond ? br.tgt_hi : br.tgt_lo;

   always_comb begin
      st_d  = st_q;
      wf_d  = wf_q;
      cnt_d = cnt_q;
      if (abort) begin
         st_d  = REST_ST;
         cnt_d = '0;
      end else if (!busy) begin
         if (trig) begin
            wf_d  = wf_map[trig_type*WF_W +: WF_W];
            st_d  = '0;
            cnt_d = '0;
         end
      end else if (is_dp) begin
         cnt_d = '0;
         if (tgt == REST_ST && br.rerun) st_d = '0;
         else                            st_d = tgt;
      end else if (hold_over) begin
         st_d  = st_q + 3'd1;
         cnt_d = '0;
      end else begin
         cnt_d = cnt_q + 8'd1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= REST_ST;
         wf_q  <= '0;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         wf_q  <= wf_d;
         cnt_q <= cnt_d;
      end
   end

   assign cur_wf  = wf_q;
   assign cur_st  = st_q;
   assign take    = busy && is_xfer && !abort;
   assign resting = !busy;

   logic unused_br;
   assign unused_br = br.spare;

endmodule

// File: rtl/wsq_engine.sv
module wsq_engine
   import wsq_pkg::*;
#(
   parameter int NUM_WF  = 4,
   parameter int N_TYPES = 4,
   parameter int DATA_W  = 8,
   localparam int WF_W   = $clog2(NUM_WF),
   localparam int TY_W   = $clog2(N_TYPES),
   localparam int ADDR_W = WF_W + $clog2(WF_BYTES)
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_we,
   input  logic [ADDR_W-1:0]       cfg_addr,
   input  logic [BYTE_W-1:0]       cfg_wdata,
   input  logic [N_TYPES*WF_W-1:0] wf_map,
   input  logic                    trig,
   input  logic [TY_W-1:0]         trig_type,
   input  logic                    abort,
   input  logic                    fifo_full,
   input  logic                    fifo_empty,
   input  logic [DATA_W-1:0]       din,
   output logic                    smp_we,
   output logic [DATA_W-1:0]       smp_data,
   output logic                    done
);

   if (NUM_WF < 2 || (1 << WF_W) != NUM_WF) begin : g_bad_wf
      $error("NUM_WF must be a power of two, at least 2");
   end
   if (N_TYPES < 2 || (1 << TY_W) != N_TYPES) begin : g_bad_ty
      $error("N_TYPES must be a power of two, at least 2");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("DATA_W must be positive");
   end

   logic [WF_W-1:0]    cur_wf;
   logic [STATE_W-1:0] cur_st;
   logic [BYTE_W-1:0]  len_br, lfunc;
   logic [1:0]         op_bits;
   logic               cond, take;

   wsq_desc_mem #(.NUM_WF(NUM_WF)) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cfg_we),
      .waddr   (cfg_addr),
      .wdata   (cfg_wdata),
      .rd_wf   (cur_wf),
      .rd_st   (cur_st),
      .len_br  (len_br),
      .op_bits (op_bits),
      .lfunc   (lfunc)
   );

   wsq_flag_eval u_flag (
      .fifo_full  (fifo_full),
      .fifo_empty (fifo_empty),
      .lfunc      (lfunc),
      .cond       (cond)
   );

   wsq_ctrl #(.NUM_WF(NUM_WF), .N_TYPES(N_TYPES)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig      (trig),
      .trig_type (trig_type),
      .wf_map    (wf_map),
      .abort     (abort),
      .len_br    (len_br),
      .op_bits   (op_bits),
      .cond      (cond),
      .cur_wf    (cur_wf),
      .cur_st    (cur_st),
      .take      (take),
      .resting   (done)
   );

   wsq_sampler #(.DATA_W(DATA_W)) u_smp (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (take),
      .din   (din),
      .we    (smp_we),
      .data  (smp_data)
   );

endmodule

// File: rtl/wsq_engine_chk.sv
module wsq_engine_chk (
   input logic clk,
   input logic rst_n,
   input logic trig,
   input logic abort,
   input logic smp_we,
   input logic done
);

   // R9: abort lands the engine at rest on the next edge
   a_r9_abort_rest: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> done);

   // R9: the abort clock captures nothing
   a_r9_abort_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !smp_we);

   // R3: a trigger at rest launches a waveform
   a_r3_trig_start: assert property (@(posedge clk) disable iff (!rst_n)
      (done && trig && !abort) |=> !done);

   // R5: a resting clock yields no capture strobe
   a_r5_rest_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !smp_we);

endmodule

bind wsq_engine wsq_engine_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .trig   (trig),
   .abort  (abort),
   .smp_we (smp_we),
   .done   (done)
);

// File: tb/sim_wsq_engine.sv
module sim_wsq_engine;

   localparam int CLK_PERIOD = 10;

   logic       clk = 0;
   logic       rst_n = 0;
   logic       cfg_we = 0;
   logic [6:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] wf_map = 8'h39;  // t0->1, t1->2, t2->3, t3->0
   logic       trig = 0;
   logic [1:0] trig_type = '0;
   logic       abort = 0;
   logic       fifo_full = 0;
   logic       fifo_empty = 0;
   logic [7:0] din = '0;
   logic       smp_we;
   logic [7:0] smp_data;
   logic       done;

   int total = 0;
   int bad = 0;
   int busy_cnt = 0;
   int we_cnt = 0;
   int cyc = 0;
   logic [7:0] cap [16];

   always #(CLK_PERIOD/2) clk = ~clk;

   wsq_engine u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .wf_map(wf_map), .trig(trig),
      .trig_type(trig_type), .abort(abort), .fifo_full(fifo_full),
      .fifo_empty(fifo_empty), .din(din), .smp_we(smp_we),
      .smp_data(smp_data), .done(done)
   );

   always @(negedge clk) begin
      din <= din + 8'd1;
      if (!done) busy_cnt++;
      if (smp_we) begin
         if (we_cnt < 16) cap[we_cnt] = smp_data;
         we_cnt++;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         total++; bad++;
         $display("FAIL watchdog act=%0d exp=<100000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic step();
      @(posedge clk); #2;
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      cfg_we = 1; cfg_addr = 7'(a); cfg_wdata = 8'(d);
      step();
      cfg_we = 0;
   endtask

   task automatic clr();
      busy_cnt = 0; we_cnt = 0;
   endtask

   task automatic launch(input int ty);
      trig = 1; trig_type = 2'(ty); clr();
      step();
      trig = 0;
   endtask

   initial begin
      step(); step();
      // R1 reset state
      chk("R1 done", int'(done), 1);
      chk("R1 smp_we", int'(smp_we), 0);
      rst_n = 1;
      step();
      // R1: unwritten descriptors are all zero -> wf0 timed len0 states, no capture
      launch(3);
      repeat (10) step();
      chk("R1 zero desc busy", busy_cnt, 7);
      chk("R1 zero desc capture", we_cnt, 0);

      // R2 layout: wf w at 32w, groups len/op/out/lf at +0/+8/+16/+24
      wr(0, 2);  wr(1, 8'h38); wr(8, 2); wr(9, 1); wr(25, 8'h36);
      wr(32, 3); wr(33, 2); wr(34, 0); wr(35, 8'h38);
      wr(40, 2); wr(41, 0); wr(42, 2); wr(43, 1); wr(59, 8'h09);
      wr(39, 8'hFF); wr(47, 8'hFF); wr(63, 8'hFF); wr(48, 8'hAA);
      wr(64, 1); wr(65, 8'hB8); wr(72, 2); wr(73, 1); wr(89, 8'h09);
      wr(96, 8'h11); wr(97, 1); wr(98, 1); wr(99, 8'h38);
      wr(104, 1); wr(105, 2); wr(106, 0); wr(107, 1); wr(123, 8'h09);
      step();

      // R2 R4 R5 R8: wf1 holds 3,2,1 then branches to rest
      launch(0);
      step(); step();
      trig = 1; trig_type = 2'd1;  // R10 busy trigger
      step();
      trig = 0;
      repeat (10) step();
      chk("R4 busy length", busy_cnt, 7);
      chk("R5 capture count", we_cnt, 4);
      chk("R5 gap01", int'(cap[1] - cap[0]), 1);
      chk("R5 gap12", int'(cap[2] - cap[1]), 1);
      chk("R4 gap23 len0", int'(cap[3] - cap[2]), 3);
      chk("R10 busy trig ignored", int'(done), 1);
      chk("R2 reserved bytes ignored", we_cnt, 4);

      // R8 rerun loop with wf2, then R9 abort
      launch(1);
      repeat (19) step();
      chk("R8 rerun busy", busy_cnt, 19);
      chk("R8 rerun captures", we_cnt, 9);
      chk("R8 still running", int'(done), 0);
      abort = 1;
      step();
      abort = 0;
      chk("R9 abort rest", int'(done), 1);
      chk("R9 abort no capture", int'(smp_we), 0);

      // R9 abort beats a trigger at rest
      abort = 1; trig = 1; trig_type = 2'd0; clr();
      step();
      abort = 0; trig = 0;
      step(); step();
      chk("R9 abort over trig", busy_cnt, 0);

      // R6 R7: wf0 loops until fifo_full
      launch(3);
      repeat (9) step();
      chk("R7 loop busy", busy_cnt, 9);
      chk("R5 loop captures", we_cnt, 6);
      chk("R6 running", int'(done), 0);
      fifo_full = 1;
      repeat (4) step();
      chk("R7 full ends", int'(done), 1);
      fifo_full = 0;
      step();

      // R6 R7 sweep: function x flags on wf3 state 0
      for (int f = 0; f < 4; f++) begin
         for (int fl = 0; fl < 4; fl++) begin
            logic a, b, r;
            a = fl[1]; b = fl[0];
            case (f)
               0: r = a & b;
               1: r = a | b;
               2: r = a ^ b;
               default: r = a & ~b;
            endcase
            wr(120, (f << 6) | (6 << 3) | 7);
            fifo_full = a; fifo_empty = b;
            launch(2);
            repeat (7) step();
            chk($sformatf("R7 f%0d fl%0d busy", f, fl), busy_cnt, r ? 3 : 4);
            chk($sformatf("R6 f%0d fl%0d cap", f, fl), we_cnt, r ? 0 : 1);
         end
      end
      fifo_full = 0; fifo_empty = 0;

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule